// File: doc/BRIEF.md
# ADC Power-Up Startup Sequencer

This block decides when the voltage references and the analog core of an ADC may be powered, and when conversions may start. When software sets the enable bit, the references are powered first. The block then waits a cold settling interval for them. Next it powers the analog core and waits a hot settling interval. After that it raises a sticky startup-done flag and grants conversions to whichever sequence request is pending.

In sleep mode the analog core is switched off whenever no sequence is running, while the references stay up. Each new sequence request then runs a fresh hot settling interval before it is granted. Software clears the done flag with a write-one strobe. Turning the enable off and on again also clears it and restarts from the cold interval.

The converter, the conversion sequencer and the register file sit outside this block. They appear here only as the enable, sleep, request, done and clear strobes.

Top module: `adc_pwr_seq`

## Requirements
- R1: During and directly after reset, ref_pwr_en, ana_pwr_en, startup_done and conv_grant are all 0.
- R2: With enable at 1 from the off state, ref_pwr_en rises one clock later. ana_pwr_en stays 0 for the next COLD_CYCLES clocks (the cold interval) and rises on the clock after that.
- R3: The hot interval keeps ana_pwr_en at 1 for HOT_CYCLES clocks (24 by default) with startup_done at 0. On the clock that ends the interval, startup_done becomes 1.
- R4: startup_done stays at 1 until a done_clr pulse clears it on the next clock. The clear does not change ana_pwr_en or conv_grant.
- R5: When done_clr is high on the same clock that the hot interval ends, startup_done becomes 1 (the set wins).
- R6: One clock after enable is 0, from any state, all four outputs are 0. A later enable runs the full cold interval again.
- R7: conv_grant is 1 only after the hot interval has finished and while a request is pending. A seq_req pulse sets the pending request, including a pulse during startup or on the clock enable rises. A seq_done while granted removes it, and conv_grant falls on the next clock.
- R8: With sleep_mode at 0, the analog core stays powered after a sequence completes.
- R9: With sleep_mode at 1 and no pending request, ana_pwr_en drops one clock after the last sequence ends or after idling in the ready state, while ref_pwr_en stays 1. A new seq_req raises ana_pwr_en on the next clock. conv_grant then follows after HOT_CYCLES more clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | ADC enable bit |
| sleep_mode | input | 1 | Power the analog core down between sequences |
| seq_req | input | 1 | Sequence trigger pulse |
| seq_done | input | 1 | Granted sequence has finished |
| done_clr | input | 1 | Write-one strobe clearing startup_done |
| ref_pwr_en | output | 1 | Reference power enable |
| ana_pwr_en | output | 1 | Analog core power enable |
| startup_done | output | 1 | Sticky startup-complete flag |
| conv_grant | output | 1 | Conversion may proceed |

## Verification
A wrong state, or a counter that is off by one, moves the rising edge of ana_pwr_en or startup_done by at least one clock. The bench therefore samples both edges of each interval at their exact cycles. A lost pending request leaves conv_grant low on the cycle the hot interval ends, so the fault shows at once. A wrong decision in sleep mode shows within one clock as ana_pwr_en staying high, or falling too early, while ref_pwr_en holds.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int COLD_CYCLES = 66000,
  parameter int HOT_CYCLES  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sleep_mode,
  input  logic seq_req,
  input  logic seq_done,
  input  logic done_clr,
  output logic ref_pwr_en,
  output logic ana_pwr_en,
  output logic startup_done,
  output logic conv_grant
);

  localparam int MAXC = (COLD_CYCLES > HOT_CYCLES) ? COLD_CYCLES : HOT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] COLD_LAST = CW'(COLD_CYCLES - 1);
  localparam logic [CW-1:0] HOT_LAST  = CW'(HOT_CYCLES - 1);

  typedef enum logic [2:0] {ST_OFF, ST_COLD, ST_HOT, ST_READY, ST_DOZE} st_t;

  st_t           state, state_n;
  logic [CW-1:0] cnt;
  logic          pend, pend_n;
  logic          cold_end, hot_end;

  assign cold_end     = (state == ST_COLD) && (cnt == COLD_LAST);
  assign hot_end      = (state == ST_HOT)  && (cnt == HOT_LAST);
  assign ref_pwr_en   = (state != ST_OFF);
  assign ana_pwr_en   = (state == ST_HOT) || (state == ST_READY);
  assign conv_grant   = (state == ST_READY) && pend;
  assign pend_n       = enable && (seq_req || (pend && !(seq_done && conv_grant)));

  always_comb begin
    state_n = state;
    if (!enable) state_n = ST_OFF;
    else begin
      case (state)
        ST_OFF:   state_n = ST_COLD;
        ST_COLD:  if (cold_end) state_n = ST_HOT;
        ST_HOT:   if (hot_end) state_n = ST_READY;
        ST_READY: if (sleep_mode && !pend_n) state_n = ST_DOZE;
        ST_DOZE:  if (pend_n || !sleep_mode) state_n = ST_HOT;
        default:  state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      state <= state_n;
      pend  <= pend_n;
      if (state_n != state) cnt <= '0;
      else if (state == ST_COLD || state == ST_HOT) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) startup_done <= 1'b0;
    else if (!enable) startup_done <= 1'b0;
    else if (hot_end) startup_done <= 1'b1;
    else if (done_clr) startup_done <= 1'b0;
  end

  p_ana_needs_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ana_pwr_en |-> ref_pwr_en);

  p_grant_needs_ana_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_grant |-> ana_pwr_en);

  p_off_when_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ref_pwr_en && !startup_done && !conv_grant));

  p_done_rise_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_done) |-> ana_pwr_en);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hot_end && done_clr) |=> startup_done);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !hot_end) |=> !startup_done);

  p_ref_before_ana_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_pwr_en) |-> !ana_pwr_en);

endmodule

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/1ps
module adc_pwr_seq_test;
  localparam int COLD = 40;
  localparam int HOT  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, sleep_mode = 0, seq_req = 0, seq_done = 0, done_clr = 0;
  logic ref_pwr_en, ana_pwr_en, startup_done, conv_grant;
  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  adc_pwr_seq #(.COLD_CYCLES(COLD), .HOT_CYCLES(HOT)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sleep_mode(sleep_mode),
    .seq_req(seq_req), .seq_done(seq_done), .done_clr(done_clr),
    .ref_pwr_en(ref_pwr_en), .ana_pwr_en(ana_pwr_en),
    .startup_done(startup_done), .conv_grant(conv_grant));

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1", "ref in reset", ref_pwr_en, 0);
    chk("R1", "ana in reset", ana_pwr_en, 0);
    chk("R1", "done in reset", startup_done, 0);
    chk("R1", "grant in reset", conv_grant, 0);
    rst_n = 1; tick(2);
    chk("R1", "ref after reset", ref_pwr_en, 0);
  endtask

  task automatic t_startup;
    enable = 1; tick(1);
    chk("R2", "ref on", ref_pwr_en, 1);
    chk("R2", "ana off at cold start", ana_pwr_en, 0);
    tick(COLD - 1);
    chk("R2", "ana off at cold end", ana_pwr_en, 0);
    tick(1);
    chk("R2", "ana on after cold", ana_pwr_en, 1);
    chk("R3", "done low at hot start", startup_done, 0);
    tick(HOT - 1);
    chk("R3", "done low at hot end", startup_done, 0);
    tick(1);
    chk("R3", "done set", startup_done, 1);
    chk("R7", "no grant without request", conv_grant, 0);
  endtask

  task automatic t_clear;
    done_clr = 1; tick(1); done_clr = 0;
    chk("R4", "done cleared", startup_done, 0);
    chk("R4", "ana kept", ana_pwr_en, 1);
    tick(3);
    chk("R4", "done stays clear", startup_done, 0);
  endtask

  task automatic t_awake;
    seq_req = 1; tick(1); seq_req = 0;
    chk("R7", "grant on request", conv_grant, 1);
    seq_done = 1; tick(1); seq_done = 0;
    chk("R7", "grant drops", conv_grant, 0);
    tick(5);
    chk("R8", "ana stays on awake", ana_pwr_en, 1);
  endtask

  task automatic t_disable;
    enable = 0; tick(1);
    chk("R6", "ref off", ref_pwr_en, 0);
    chk("R6", "ana off", ana_pwr_en, 0);
    chk("R6", "done cleared", startup_done, 0);
    enable = 1; seq_req = 1; tick(1); seq_req = 0;
    tick(COLD - 1);
    chk("R6", "cold rerun", ana_pwr_en, 0);
    tick(HOT);
    chk("R7", "held request not yet granted", conv_grant, 0);
    tick(1);
    chk("R7", "held request granted", conv_grant, 1);
    chk("R6", "done after restart", startup_done, 1);
    seq_done = 1; tick(1); seq_done = 0;
  endtask

  task automatic t_sleep;
    sleep_mode = 1; tick(1);
    chk("R9", "ana off in idle", ana_pwr_en, 0);
    chk("R9", "ref on in idle", ref_pwr_en, 1);
    tick(5);
    chk("R9", "stays dozing", ana_pwr_en, 0);
    seq_req = 1; tick(1); seq_req = 0;
    chk("R9", "ana on for request", ana_pwr_en, 1);
    tick(HOT - 1);
    chk("R9", "no grant during hot", conv_grant, 0);
    tick(1);
    chk("R9", "grant after hot", conv_grant, 1);
    seq_done = 1; tick(1); seq_done = 0;
    chk("R9", "ana off after sequence", ana_pwr_en, 0);
    chk("R9", "grant off after sequence", conv_grant, 0);
    chk("R9", "ref kept after sequence", ref_pwr_en, 1);
  endtask

  task automatic t_collision;
    done_clr = 1; tick(1); done_clr = 0;
    chk("R4", "done cleared in sleep", startup_done, 0);
    seq_req = 1; tick(1); seq_req = 0;
    tick(HOT - 1);
    done_clr = 1; tick(1); done_clr = 0;
    chk("R5", "set wins", startup_done, 1);
    seq_done = 1; tick(1); seq_done = 0;
  endtask

  task automatic t_mid_hot_off;
    seq_req = 1; tick(1); seq_req = 0;
    tick(5);
    enable = 0; tick(1);
    chk("R6", "ana off mid hot", ana_pwr_en, 0);
    chk("R6", "ref off mid hot", ref_pwr_en, 0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    t_reset;
    t_startup;
    t_clear;
    t_awake;
    t_disable;
    t_sleep;
    t_collision;
    t_mid_hot_off;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule